// File: doc/BRIEF.md
# Gradient Non-Maximum Suppression Unit

This unit thins edges in a gradient image. It takes the horizontal and vertical gradient components of each pixel as a stream, one pixel per clock, in raster order. Frames of a fixed size follow one another with no gap in the pixel count. For every pixel it forms the gradient magnitude |dx|+|dy| and keeps a 3×3 window of magnitudes, using two line delays. It then decides whether the centre pixel is a ridge along its own gradient direction. If it is, the unit passes the magnitude on. If it is not, the unit outputs zero.

The direction is not computed as an angle. The unit compares |dx| with |dy| to find the dominant axis, and the two sign bits pick the quadrant. Along the gradient it looks at the two opposite neighbours, and each is a linear blend of an axial pixel and a diagonal pixel. The blend weight is minor/major. To stay exact, the comparison multiplies both sides by the major component, so no divider is needed and no rounding occurs. Five multipliers run side by side, one for the centre and two for each neighbour.

Results leave the unit in raster order, one per accepted pixel. The result for a pixel appears once the pixel one row and one column past it has been accepted. The last row of a frame is therefore flushed by the first pixels of the next frame.

Top module: `grad_nms`

## Requirements
- R1: While reset is held, and after reset until the (IMG_W+2)-th accepted pixel, out_valid stays low.
- R2: Pixels are numbered k = 0,1,2,... from reset, in raster order across back-to-back frames of IMG_W×IMG_H. The result for pixel k appears with out_valid high exactly 4 clock cycles after the cycle in which pixel k+IMG_W+1 is accepted (in_valid high at a rising edge). out_valid is high in no other cycle.
- R3: dx and dy are DW-bit two's complement values, and the magnitude is |dx|+|dy| as an unsigned DW+1-bit value. A kept pixel outputs its magnitude, and a suppressed pixel outputs 0.
- R4: A pixel in the first or last row, or in the first or last column, of its frame always outputs 0.
- R5: When |dx| ≥ |dy|, major=|dx| and minor=|dy|. The forward neighbour blends A, the pixel one column over in the direction of dx, with B, the pixel one column over and one row over in the direction of dy. Its value is (A·(major−minor)+B·minor)/major. The backward neighbour uses the mirrored pixels.
- R6: When |dy| > |dx|, major=|dy| and minor=|dx|. A is the pixel one row over in the direction of dy, and B is the diagonal pixel one row and one column over. The backward neighbour is mirrored and the blend is the same as in R5.
- R7: Sign-bit rule: a positive dx (or zero) points to the next column to the right, and a negative dx points to the left. A positive dy (or zero) points to the next row down, and a negative dy points up.
- R8: An interior pixel with magnitude M is kept only if M·major is strictly greater than the scaled forward blend A·(major−minor)+B·minor. It must also be greater than or equal to the scaled backward blend. Both comparisons are exact, with no rounding.
- R9: Equality is broken asymmetrically. A pixel equal to its forward neighbour is suppressed, and a pixel equal to its backward neighbour is kept. A two-pixel plateau along the gradient therefore leaves one pixel.
- R10: The unit accepts a pixel on every clock. Idle cycles between accepted pixels change no result value and only delay the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A pixel is offered this cycle |
| in_dx | input | DW | Horizontal gradient component, two's complement |
| in_dy | input | DW | Vertical gradient component, two's complement |
| out_valid | output | 1 | out_mag holds a result this cycle |
| out_mag | output | DW+1 | Suppressed magnitude of the result pixel |

## Verification
The bench drives ramps that peak in one column and then in one row, to separate the horizontal and vertical sectors. A design with the axes swapped, or with a wrong sign-to-quadrant map, would keep the wrong pixel or keep none. A two-pixel plateau along the gradient checks the tie rule: symmetric handling would keep both pixels or drop both. Full-scale values such as −128 check the absolute value and the product widths, where truncation would corrupt the comparison. Runs with random idle gaps check that window alignment and the output lag survive bubbles, since a window that shifted on idle cycles would pair the wrong neighbours. Border pixels are checked to come out as zero even though their window wraps into the adjacent row or frame.

// File: rtl/nms_pkg.sv
package nms_pkg;

  typedef enum logic {
    DOM_HORZ = 1'b0,
    DOM_VERT = 1'b1
  } dom_e;

  // true when a coordinate sits on the first or last index of its axis
  function automatic logic on_rim(input int pos, input int len);
    return (pos == 0) || (pos == len - 1);
  endfunction

endpackage

// File: rtl/nms_line_delay.sv
module nms_line_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [WIDTH-1:0] dout_q;

  always_comb begin
    ptr_d = ptr_q;
    if (en) begin
      if (ptr_q == AW'(DEPTH - 1)) ptr_d = '0;
      else                         ptr_d = ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // read-before-write: a word comes back DEPTH enables after it went in
  always_ff @(posedge clk) begin
    if (en) begin
      dout_q       <= mem[ptr_q];
      mem[ptr_q]   <= din;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/nms_sector_sel.sv
module nms_sector_sel
  import nms_pkg::*;
#(
  parameter int DW = 8,
  parameter int MW = DW + 1
) (
  input  logic [2:0][2:0][MW-1:0] win_i,   // [row][col], row 0 top, col 0 left
  input  logic [DW-1:0]           dx_i,
  input  logic [DW-1:0]           dy_i,
  output logic [MW-1:0]           cen_o,
  output logic [MW-1:0]           fa_o,    // forward axial
  output logic [MW-1:0]           fb_o,    // forward diagonal
  output logic [MW-1:0]           ba_o,    // backward axial
  output logic [MW-1:0]           bb_o,    // backward diagonal
  output logic [DW-1:0]           maj_o,
  output logic [DW-1:0]           mnr_o
);
  logic [DW-1:0] ax, ay;
  logic [1:0]    c_fw, c_bw, r_fw, r_bw;
  dom_e          dom;

  always_comb begin
    ax   = dx_i[DW-1] ? (~dx_i + DW'(1)) : dx_i;
    ay   = dy_i[DW-1] ? (~dy_i + DW'(1)) : dy_i;
    dom  = (ax >= ay) ? DOM_HORZ : DOM_VERT;
    c_fw = dx_i[DW-1] ? 2'd0 : 2'd2;
    c_bw = 2'd2 - c_fw;
    r_fw = dy_i[DW-1] ? 2'd0 : 2'd2;
    r_bw = 2'd2 - r_fw;
    cen_o = win_i[1][1];
    fb_o  = win_i[r_fw][c_fw];
    bb_o  = win_i[r_bw][c_bw];
    if (dom == DOM_HORZ) begin
      maj_o = ax;
      mnr_o = ay;
      fa_o  = win_i[1][c_fw];
      ba_o  = win_i[1][c_bw];
    end else begin
      maj_o = ay;
      mnr_o = ax;
      fa_o  = win_i[r_fw][1];
      ba_o  = win_i[r_bw][1];
    end
  end

endmodule

// File: rtl/nms_interp_cmp.sv
module nms_interp_cmp #(
  parameter int DW = 8,
  parameter int MW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_i,
  input  logic          rim_i,
  input  logic [MW-1:0] cen_i,
  input  logic [MW-1:0] fa_i,
  input  logic [MW-1:0] fb_i,
  input  logic [MW-1:0] ba_i,
  input  logic [MW-1:0] bb_i,
  input  logic [DW-1:0] maj_i,
  input  logic [DW-1:0] mnr_i,
  output logic          v_o,
  output logic [MW-1:0] mag_o
);
  localparam int PW = MW + DW;
  localparam int SW = PW + 1;

  // stage B: five products in parallel
  logic [DW-1:0] wt_ax;
  logic [PW-1:0] pc_d, pfa_d, pfb_d, pba_d, pbb_d;
  logic          bv_q, b_rim;
  logic [MW-1:0] b_cen;
  logic [PW-1:0] pc_q, pfa_q, pfb_q, pba_q, pbb_q;

  always_comb begin
    wt_ax = maj_i - mnr_i;
    pc_d  = {{DW{1'b0}}, cen_i} * {{MW{1'b0}}, maj_i};
    pfa_d = {{DW{1'b0}}, fa_i}  * {{MW{1'b0}}, wt_ax};
    pfb_d = {{DW{1'b0}}, fb_i}  * {{MW{1'b0}}, mnr_i};
    pba_d = {{DW{1'b0}}, ba_i}  * {{MW{1'b0}}, wt_ax};
    pbb_d = {{DW{1'b0}}, bb_i}  * {{MW{1'b0}}, mnr_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bv_q <= 1'b0;
    else        bv_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      b_rim <= rim_i;
      b_cen <= cen_i;
      pc_q  <= pc_d;
      pfa_q <= pfa_d;
      pfb_q <= pfb_d;
      pba_q <= pba_d;
      pbb_q <= pbb_d;
    end
  end

  // stage C: sum, compare, select
  logic [SW-1:0] sc, sf, sb;
  logic          keep;
  logic [MW-1:0] mag_d;

  always_comb begin
    sc    = {1'b0, pc_q};
    sf    = {1'b0, pfa_q} + {1'b0, pfb_q};
    sb    = {1'b0, pba_q} + {1'b0, pbb_q};
    keep  = !b_rim && (sc > sf) && (sc >= sb);
    mag_d = keep ? b_cen : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= bv_q;
  end

  always_ff @(posedge clk) begin
    if (bv_q) mag_o <= mag_d;
  end

  // R4
  rim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bv_q && b_rim) |=> (v_o && mag_o == '0));

  // R9
  fwd_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bv_q && !b_rim && sc == sf) |=> (v_o && mag_o == '0));

  // R3
  kept_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_o && mag_o != '0) |-> (mag_o == $past(b_cen)));

endmodule

// File: rtl/grad_nms.sv
module grad_nms
  import nms_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IMG_W = 16,
  parameter int IMG_H = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_dx,
  input  logic [DW-1:0] in_dy,
  output logic          out_valid,
  output logic [DW:0]   out_mag
);
  localparam int MW    = DW + 1;
  localparam int EW    = MW + 2 * DW;
  localparam int XW    = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int YW    = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int PRIME = IMG_W + 1;
  localparam int PCW   = $clog2(PRIME + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // stage 0: register the pixel and its magnitude
  logic [DW-1:0] in_ax, in_ay;
  logic [MW-1:0] in_mag;
  logic          v0_q;
  logic [DW-1:0] dx0_q, dy0_q;
  logic [MW-1:0] mag0_q;

  always_comb begin
    in_ax  = in_dx[DW-1] ? (~in_dx + DW'(1)) : in_dx;
    in_ay  = in_dy[DW-1] ? (~in_dy + DW'(1)) : in_dy;
    in_mag = {1'b0, in_ax} + {1'b0, in_ay};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) v0_q <= 1'b0;
    else         v0_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      dx0_q  <= in_dx;
      dy0_q  <= in_dy;
      mag0_q <= in_mag;
    end
  end

  logic push;
  assign push = v0_q;

  // line delays: middle row carries components, top row magnitude only
  logic [EW-1:0] lb_mid_out;
  logic [MW-1:0] lb_top_out;

  nms_line_delay #(.WIDTH(EW), .DEPTH(IMG_W)) u_lb_mid (
    .clk  (clk),
    .rst_n(rst_ni),
    .en   (push),
    .din  ({mag0_q, dx0_q, dy0_q}),
    .dout (lb_mid_out)
  );

  nms_line_delay #(.WIDTH(MW), .DEPTH(IMG_W - 1)) u_lb_top (
    .clk  (clk),
    .rst_n(rst_ni),
    .en   (push),
    .din  (lb_mid_out[EW-1 -: MW]),
    .dout (lb_top_out)
  );

  // window registers
  logic [MW-1:0] bot0_q, bot1_q, bot2_q;
  logic [MW-1:0] mid0_q, mid1_q;
  logic [DW-1:0] cdx_q, cdy_q;
  logic [MW-1:0] top0_q, top1_q;

  always_ff @(posedge clk) begin
    if (push) begin
      bot2_q <= mag0_q;
      bot1_q <= bot2_q;
      bot0_q <= bot1_q;
      mid1_q <= lb_mid_out[EW-1 -: MW];
      cdx_q  <= lb_mid_out[2*DW-1 -: DW];
      cdy_q  <= lb_mid_out[DW-1:0];
      mid0_q <= mid1_q;
      top1_q <= lb_top_out;
      top0_q <= top1_q;
    end
  end

  logic [2:0][2:0][MW-1:0] win;
  always_comb begin
    win[0][0] = top0_q;
    win[0][1] = top1_q;
    win[0][2] = lb_top_out;
    win[1][0] = mid0_q;
    win[1][1] = mid1_q;
    win[1][2] = lb_mid_out[EW-1 -: MW];
    win[2][0] = bot0_q;
    win[2][1] = bot1_q;
    win[2][2] = bot2_q;
  end

  // priming and centre coordinates
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           primed;
  logic [XW-1:0]  nx_q, nx_d, wcx_q;
  logic [YW-1:0]  ny_q, ny_d, wcy_q;
  logic           wv_q;

  always_comb begin
    primed = (pcnt_q == PCW'(PRIME));
    pcnt_d = pcnt_q;
    nx_d   = nx_q;
    ny_d   = ny_q;
    if (push && !primed) pcnt_d = pcnt_q + PCW'(1);
    if (push && primed) begin
      if (nx_q == XW'(IMG_W - 1)) begin
        nx_d = '0;
        ny_d = (ny_q == YW'(IMG_H - 1)) ? '0 : ny_q + YW'(1);
      end else begin
        nx_d = nx_q + XW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      nx_q   <= '0;
      ny_q   <= '0;
      wv_q   <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      nx_q   <= nx_d;
      ny_q   <= ny_d;
      wv_q   <= push && primed;
    end
  end

  always_ff @(posedge clk) begin
    if (push && primed) begin
      wcx_q <= nx_q;
      wcy_q <= ny_q;
    end
  end

  // stage A: sector selection
  logic          w_rim;
  logic [MW-1:0] s_cen, s_fa, s_fb, s_ba, s_bb;
  logic [DW-1:0] s_maj, s_mnr;

  assign w_rim = on_rim(int'(wcx_q), IMG_W) || on_rim(int'(wcy_q), IMG_H);

  nms_sector_sel #(.DW(DW), .MW(MW)) u_sector (
    .win_i(win),
    .dx_i (cdx_q),
    .dy_i (cdy_q),
    .cen_o(s_cen),
    .fa_o (s_fa),
    .fb_o (s_fb),
    .ba_o (s_ba),
    .bb_o (s_bb),
    .maj_o(s_maj),
    .mnr_o(s_mnr)
  );

  logic          av_q, a_rim;
  logic [MW-1:0] a_cen, a_fa, a_fb, a_ba, a_bb;
  logic [DW-1:0] a_maj, a_mnr;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) av_q <= 1'b0;
    else         av_q <= wv_q;
  end

  always_ff @(posedge clk) begin
    if (wv_q) begin
      a_rim <= w_rim;
      a_cen <= s_cen;
      a_fa  <= s_fa;
      a_fb  <= s_fb;
      a_ba  <= s_ba;
      a_bb  <= s_bb;
      a_maj <= s_maj;
      a_mnr <= s_mnr;
    end
  end

  // stages B and C
  nms_interp_cmp #(.DW(DW), .MW(MW)) u_cmp (
    .clk  (clk),
    .rst_n(rst_ni),
    .v_i  (av_q),
    .rim_i(a_rim),
    .cen_i(a_cen),
    .fa_i (a_fa),
    .fb_i (a_fb),
    .ba_i (a_ba),
    .bb_i (a_bb),
    .maj_i(a_maj),
    .mnr_i(a_mnr),
    .v_o  (out_valid),
    .mag_o(out_mag)
  );

  // R2
  out_lag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (push && primed) |-> ##4 out_valid);

  // R1
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> primed);

endmodule

// File: tb/grad_nms_tb.sv
`timescale 1ns/100ps
module grad_nms_tb;
  localparam int DW = 8;
  localparam int W  = 16;
  localparam int H  = 12;
  localparam int FR = W * H;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_dx = '0;
  logic [DW-1:0] in_dy = '0;
  logic          out_valid;
  logic [DW:0]   out_mag;

  grad_nms #(.DW(DW), .IMG_W(W), .IMG_H(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dx(in_dx),
    .in_dy(in_dy), .out_valid(out_valid), .out_mag(out_mag)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    checking = 1'b0;
  string phase_tag = "R3";

  int    gdx[$];
  int    gdy[$];
  int    exp_cyc[$];
  int    exp_val[$];
  int    exp_idx[$];
  string exp_tag[$];

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int mg(input int i);
    return iabs(gdx[i]) + iabs(gdy[i]);
  endfunction

  // reference: exact scaled comparison per R5..R9
  function automatic int ref_px(input int c);
    int fp, x, y, ax, ay, sx, sy, maj, mnr, m, fwd, bwd;
    fp = c % FR;
    x  = fp % W;
    y  = fp / W;
    if (x == 0 || x == W - 1 || y == 0 || y == H - 1) return 0;
    ax = iabs(gdx[c]);
    ay = iabs(gdy[c]);
    sx = (gdx[c] < 0) ? -1 : 1;
    sy = (gdy[c] < 0) ? -1 : 1;
    m  = mg(c);
    if (ax >= ay) begin
      maj = ax; mnr = ay;
      fwd = mg(c + sx) * (maj - mnr) + mg(c + sy * W + sx) * mnr;
      bwd = mg(c - sx) * (maj - mnr) + mg(c - sy * W - sx) * mnr;
    end else begin
      maj = ay; mnr = ax;
      fwd = mg(c + sy * W) * (maj - mnr) + mg(c + sy * W + sx) * mnr;
      bwd = mg(c - sy * W) * (maj - mnr) + mg(c - sy * W - sx) * mnr;
    end
    if ((m * maj > fwd) && (m * maj >= bwd)) return m;
    return 0;
  endfunction

  task automatic send(input int dx, input int dy);
    int g, c, fp;
    @(negedge clk);
    in_valid = 1'b1;
    in_dx = DW'(dx);
    in_dy = DW'(dy);
    gdx.push_back(dx);
    gdy.push_back(dy);
    g = gdx.size() - 1;
    if (g >= W + 1) begin
      c  = g - W - 1;
      fp = c % FR;
      exp_cyc.push_back(cyc + 5);
      exp_val.push_back(ref_px(c));
      exp_idx.push_back(c);
      if ((fp % W) == 0 || (fp % W) == W - 1 || fp / W == 0 || fp / W == H - 1)
        exp_tag.push_back("R4");
      else
        exp_tag.push_back(phase_tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // per-clock comparison against the reference queue (R2 timing)
  always @(negedge clk) begin
    if (checking) begin
      n_cmp++;
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        if (!out_valid || out_mag !== (DW+1)'(exp_val[0])) begin
          n_bad++;
          $display("FAIL %s: pixel %0d actual valid=%0b mag=%0d expected valid=1 mag=%0d",
                   exp_tag[0], exp_idx[0], out_valid, out_mag, exp_val[0]);
        end
        void'(exp_cyc.pop_front());
        void'(exp_val.pop_front());
        void'(exp_idx.pop_front());
        void'(exp_tag.pop_front());
      end else if (out_valid) begin
        n_bad++;
        $display("FAIL R2: cycle %0d actual valid=1 mag=%0d expected valid=0", cyc, out_mag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: quiet while in reset
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      n_cmp++;
      if (out_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R1: in reset actual valid=%0b expected valid=0", out_valid);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;
    idle(4);

    // R3, R8: random full-range frame, back to back
    phase_tag = "R8";
    for (int i = 0; i < FR; i++)
      send($urandom_range(255) - 128, $urandom_range(255) - 128);

    // R5: ridge across columns, horizontal dominant
    phase_tag = "R5";
    for (int i = 0; i < FR; i++) begin
      int x = i % W, y = i / W;
      send(10 + 6 * (8 - iabs(x - 8)), (y % 3) - 1);
    end

    // R6: ridge across rows, vertical dominant
    phase_tag = "R6";
    for (int i = 0; i < FR; i++) begin
      int x = i % W, y = i / W;
      send((x % 3) - 1, 10 + 6 * (6 - iabs(y - 6)));
    end

    // R7: negative signs, diagonal mixture
    phase_tag = "R7";
    for (int i = 0; i < FR; i++) begin
      int x = i % W, y = i / W;
      send(-(5 + 4 * (8 - iabs(x - 8))), -(5 + 3 * (6 - iabs(y - 6))));
    end

    // R9: two-pixel plateau along the gradient
    phase_tag = "R9";
    for (int i = 0; i < FR; i++) begin
      int x = i % W;
      send((x == 7 || x == 8) ? 40 : 20, 0);
    end

    // R8: extreme component values
    phase_tag = "R8";
    for (int i = 0; i < FR; i++) begin
      int pick[5] = '{-128, 127, -1, 0, 1};
      send(pick[$urandom_range(4)], pick[$urandom_range(4)]);
    end

    // R10: random values with idle gaps
    phase_tag = "R10";
    for (int i = 0; i < FR; i++) begin
      send($urandom_range(255) - 128, $urandom_range(255) - 128);
      if ($urandom_range(9) < 3) idle($urandom_range(3) + 1);
    end

    // flush the last frame's trailing results
    phase_tag = "R3";
    for (int i = 0; i < W + 1; i++) send(0, 0);
    idle(12);

    n_cmp++;
    if (exp_cyc.size() != 0) begin
      n_bad++;
      $display("FAIL R2: results outstanding actual=%0d expected=0", exp_cyc.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule